// File: doc/BRIEF.md
# Masked Coprocessor Control Register File

This block holds the 32-bit system-control registers of a processor core. Each register is reached by a 5-bit register number and a 3-bit select, which together form the flat index `number*8 + select`. Every implemented register has a reset value and a write mask. A software write keeps the bits that the mask marks read-only and replaces only the writable bits. A second, raw write port lets hardware load any register directly and ignores the mask.

Registers come in three kinds. One kind has a single copy for the whole processor. One kind has a copy per thread context, picked by the accessing thread ID. One kind has a copy per virtual processor, picked by the virtual-processor field that sits in the accessing thread's binding register. Reads are combinational from the resolved copy. Each software write also raises a pending-update flag, which tells downstream logic to re-evaluate thread state. While that flag is set, further writes do not issue another request.

Top module: `ccr_regfile`

## Requirements
- R1: The slot is located by register number and select together. For example, number 15 select 1 (flat index 121) is the exception-base register, and number 15 select 0 (flat index 120) is the processor-ID register.
- R2: A software write stores `(wdata & mask) | (old & ~mask)`. Bits with a clear mask bit keep their previous value.
- R3: The write masks by flat index are: 0 → 0x7FFFFFFF, 16 and 24 → 0x3FFFFFFF, 32 → 0xFF800000, 40 → 0x1FFFF800, 41 → 0x10000000, 96 → 0xFF78FF17, 97 → 0x000003E0, 98 → 0x0000F3C0, 104 → 0x08C00300, 121 → 0x3FFFF000, 128 → 0x7FFF0007, 130 → 0x7000F000. The slots 9, 17, 18 and 20 are fully writable.
- R4: The slots 8, 64, 120, 129, 131 and 136 have mask 0, so a software write leaves them unchanged.
- R5: The reset values are as follows. Index 8 holds 0x3F. Index 121 and index 128 hold 0x80000000. Index 96 holds 0x00400004, with bits 22 and 2 set. The binding register at index 18 holds `tid << 21` for thread `tid`. Every other slot resets to 0.
- R6: The slots 17, 18, 20, 96 and 136 have one copy per thread context, selected by the accessing thread ID.
- R7: The slots 9 and 121 have one copy per virtual processor. The copy is selected by bits `[VPE_W-1:0]` of the binding register (index 18) of the accessing thread.
- R8: A raw write stores its data in full, with no mask applied, into the slot and copy resolved from the raw port's own thread ID. This holds for read-only slots as well.
- R9: When the raw and software ports write the same slot and copy in the same cycle, the raw value is kept.
- R10: A slot that is not implemented reads as 0, and writes to it have no effect.
- R11: A software write sets `upd_pend`. When no update was pending, it also raises `upd_pulse` for one cycle on the following cycle. A write while `upd_pend` is set and `upd_ack` is low produces no pulse. `upd_ack` clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_tid | input | TID_W | Thread issuing the software access |
| sw_reg | input | 5 | Software register number |
| sw_sel | input | 3 | Software select |
| sw_wen | input | 1 | Software masked write enable |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Combinational read of the addressed copy |
| hw_wen | input | 1 | Raw write enable |
| hw_tid | input | TID_W | Thread used to resolve the raw write's copy |
| hw_reg | input | 5 | Raw register number |
| hw_sel | input | 3 | Raw select |
| hw_wdata | input | 32 | Raw write data |
| upd_ack | input | 1 | Clears the pending-update flag |
| upd_pend | output | 1 | Pending-update flag |
| upd_pulse | output | 1 | One-cycle request for a new update |

## Verification
The bench builds the block with four thread contexts and two virtual processors. With four contexts, a thread whose own copies stay at their reset values can be compared against a thread that has been written. With two virtual-processor copies, rebinding one thread to copy 1 makes its virtual-processor reads and raw writes separate from threads still bound to copy 0. The default of two threads exercises the same paths with smaller selectors.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int XLEN     = 32;
   localparam int IDX_W    = 8;
   localparam int SLOT_W   = 4;
   localparam int N_GLOBAL = 16;
   localparam int N_TCREG  = 5;
   localparam int N_VPEREG = 2;
   localparam int TCB_SLOT = 1;
   localparam int TCB_TID_LSB = 21;

   typedef enum logic [1:0] {BK_NONE, BK_GLOBAL, BK_VPE, BK_TC} bank_e;

   typedef struct packed {
      bank_e             bank;
      logic [SLOT_W-1:0] slot;
   } place_t;

   function automatic place_t mk(input bank_e b, input int s);
      place_t p;
      p.bank = b;
      p.slot = SLOT_W'(s);
      return p;
   endfunction

   function automatic place_t place_of(input logic [IDX_W-1:0] idx);
      case (idx)
         8'd0:    return mk(BK_GLOBAL, 0);
         8'd8:    return mk(BK_GLOBAL, 1);
         8'd16:   return mk(BK_GLOBAL, 2);
         8'd24:   return mk(BK_GLOBAL, 3);
         8'd32:   return mk(BK_GLOBAL, 4);
         8'd40:   return mk(BK_GLOBAL, 5);
         8'd41:   return mk(BK_GLOBAL, 6);
         8'd64:   return mk(BK_GLOBAL, 7);
         8'd97:   return mk(BK_GLOBAL, 8);
         8'd98:   return mk(BK_GLOBAL, 9);
         8'd104:  return mk(BK_GLOBAL, 10);
         8'd120:  return mk(BK_GLOBAL, 11);
         8'd128:  return mk(BK_GLOBAL, 12);
         8'd129:  return mk(BK_GLOBAL, 13);
         8'd130:  return mk(BK_GLOBAL, 14);
         8'd131:  return mk(BK_GLOBAL, 15);
         8'd17:   return mk(BK_TC, 0);
         8'd18:   return mk(BK_TC, TCB_SLOT);
         8'd20:   return mk(BK_TC, 2);
         8'd96:   return mk(BK_TC, 3);
         8'd136:  return mk(BK_TC, 4);
         8'd9:    return mk(BK_VPE, 0);
         8'd121:  return mk(BK_VPE, 1);
         default: return mk(BK_NONE, 0);
      endcase
   endfunction

   function automatic logic [XLEN-1:0] wmask_of(input logic [IDX_W-1:0] idx);
      case (idx)
         8'd0:                      return 32'h7FFF_FFFF;
         8'd16, 8'd24:              return 32'h3FFF_FFFF;
         8'd32:                     return 32'hFF80_0000;
         8'd40:                     return 32'h1FFF_F800;
         8'd41:                     return 32'h1000_0000;
         8'd96:                     return 32'hFF78_FF17;
         8'd97:                     return 32'h0000_03E0;
         8'd98:                     return 32'h0000_F3C0;
         8'd104:                    return 32'h08C0_0300;
         8'd121:                    return 32'h3FFF_F000;
         8'd128:                    return 32'h7FFF_0007;
         8'd130:                    return 32'h7000_F000;
         8'd9, 8'd17, 8'd18, 8'd20: return 32'hFFFF_FFFF;
         default:                   return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] glob_rst(input int s);
      case (s)
         1:       return 32'h0000_003F;
         12:      return 32'h8000_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] tc_rst(input int s, input int tid);
      case (s)
         TCB_SLOT: return XLEN'(tid) << TCB_TID_LSB;
         3:        return 32'h0040_0004;
         default:  return 32'h0;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] vpe_rst(input int s);
      return (s == 1) ? 32'h8000_0000 : 32'h0;
   endfunction

endpackage

// File: rtl/ccr_locate.sv
module ccr_locate
   import ccr_pkg::*;
#(
   parameter int NUM_TC  = 2,
   parameter int NUM_VPE = 2,
   localparam int TID_W  = (NUM_TC  > 1) ? $clog2(NUM_TC)  : 1,
   localparam int VPE_W  = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
   input  logic [4:0]                   rnum,
   input  logic [2:0]                   sel,
   input  logic [TID_W-1:0]             tid,
   input  logic [NUM_TC-1:0][VPE_W-1:0] tcb_vpe,
   output place_t                       pl,
   output logic [VPE_W-1:0]             vpe_sel
);
   assign pl = place_of({rnum, sel});

   generate
      if (NUM_VPE == 1) begin : g_single_vpe
         logic unused_vpe;
         assign unused_vpe = ^tcb_vpe;
         assign vpe_sel    = '0;
      end else begin : g_multi_vpe
         assign vpe_sel = tcb_vpe[tid];
      end
   endgenerate
endmodule

// File: rtl/ccr_merge.sv
module ccr_merge
   import ccr_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   input  logic [XLEN-1:0]  cur_val,
   input  logic [XLEN-1:0]  new_val,
   output logic [XLEN-1:0]  merged
);
   logic [XLEN-1:0] m;
   assign m      = wmask_of(idx);
   assign merged = (new_val & m) | (cur_val & ~m);
endmodule

// File: rtl/ccr_upd_flag.sv
module ccr_upd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic ack,
   output logic pend,
   output logic pulse
);
   logic busy;
   assign busy = pend & ~ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         pulse <= 1'b0;
      end else begin
         pend  <= wr | busy;
         pulse <= wr & ~busy;
      end
   end

   AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(wr)); // R11
   AST_NO_REQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !ack && wr) |=> !pulse); // R11
   AST_PULSE_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> pend); // R11
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
   import ccr_pkg::*;
#(
   parameter int NUM_TC  = 2,
   parameter int NUM_VPE = 2,
   localparam int TID_W  = (NUM_TC  > 1) ? $clog2(NUM_TC)  : 1,
   localparam int VPE_W  = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] sw_tid,
   input  logic [4:0]       sw_reg,
   input  logic [2:0]       sw_sel,
   input  logic             sw_wen,
   input  logic [31:0]      sw_wdata,
   output logic [31:0]      sw_rdata,
   input  logic             hw_wen,
   input  logic [TID_W-1:0] hw_tid,
   input  logic [4:0]       hw_reg,
   input  logic [2:0]       hw_sel,
   input  logic [31:0]      hw_wdata,
   input  logic             upd_ack,
   output logic             upd_pend,
   output logic             upd_pulse
);
   generate
      if (NUM_TC < 1 || (NUM_TC & (NUM_TC - 1)) != 0 || NUM_TC > 256) begin : g_bad_tc
         $error("NUM_TC must be a power of two no larger than 256");
      end
      if (NUM_VPE < 1 || (NUM_VPE & (NUM_VPE - 1)) != 0 || VPE_W > TCB_TID_LSB) begin : g_bad_vpe
         $error("NUM_VPE must be a power of two that fits below the thread field");
      end
   endgenerate

   logic [XLEN-1:0] g_q [N_GLOBAL];
   logic [XLEN-1:0] t_q [NUM_TC][N_TCREG];
   logic [XLEN-1:0] v_q [NUM_VPE][N_VPEREG];

   logic [NUM_TC-1:0][VPE_W-1:0] tcb_vpe;
   for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
      assign tcb_vpe[t] = t_q[t][TCB_SLOT][VPE_W-1:0];
   end

   place_t           sw_pl, hw_pl;
   logic [VPE_W-1:0] sw_vsel, hw_vsel;
   logic [XLEN-1:0]  sw_merged;

   ccr_locate #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE)) u_loc_sw (
      .rnum(sw_reg), .sel(sw_sel), .tid(sw_tid), .tcb_vpe(tcb_vpe),
      .pl(sw_pl), .vpe_sel(sw_vsel));

   ccr_locate #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE)) u_loc_hw (
      .rnum(hw_reg), .sel(hw_sel), .tid(hw_tid), .tcb_vpe(tcb_vpe),
      .pl(hw_pl), .vpe_sel(hw_vsel));

   always_comb begin
      case (sw_pl.bank)
         BK_GLOBAL: sw_rdata = g_q[sw_pl.slot];
         BK_TC:     sw_rdata = (int'(sw_pl.slot) < N_TCREG)  ? t_q[sw_tid][sw_pl.slot[2:0]]  : '0;
         BK_VPE:    sw_rdata = (int'(sw_pl.slot) < N_VPEREG) ? v_q[sw_vsel][sw_pl.slot[0]]  : '0;
         default:   sw_rdata = '0;
      endcase
   end

   ccr_merge u_merge (
      .idx({sw_reg, sw_sel}), .cur_val(sw_rdata), .new_val(sw_wdata), .merged(sw_merged));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < N_GLOBAL; s++) g_q[s] <= glob_rst(s);
         for (int t = 0; t < NUM_TC; t++)
            for (int s = 0; s < N_TCREG; s++) t_q[t][s] <= tc_rst(s, t);
         for (int v = 0; v < NUM_VPE; v++)
            for (int s = 0; s < N_VPEREG; s++) v_q[v][s] <= vpe_rst(s);
      end else begin
         for (int s = 0; s < N_GLOBAL; s++) begin
            if (hw_wen && hw_pl.bank == BK_GLOBAL && hw_pl.slot == SLOT_W'(s))
               g_q[s] <= hw_wdata;
            else if (sw_wen && sw_pl.bank == BK_GLOBAL && sw_pl.slot == SLOT_W'(s))
               g_q[s] <= sw_merged;
         end
         for (int t = 0; t < NUM_TC; t++) begin
            for (int s = 0; s < N_TCREG; s++) begin
               if (hw_wen && hw_pl.bank == BK_TC && hw_tid == TID_W'(t) && hw_pl.slot == SLOT_W'(s))
                  t_q[t][s] <= hw_wdata;
               else if (sw_wen && sw_pl.bank == BK_TC && sw_tid == TID_W'(t) && sw_pl.slot == SLOT_W'(s))
                  t_q[t][s] <= sw_merged;
            end
         end
         for (int v = 0; v < NUM_VPE; v++) begin
            for (int s = 0; s < N_VPEREG; s++) begin
               if (hw_wen && hw_pl.bank == BK_VPE && hw_vsel == VPE_W'(v) && hw_pl.slot == SLOT_W'(s))
                  v_q[v][s] <= hw_wdata;
               else if (sw_wen && sw_pl.bank == BK_VPE && sw_vsel == VPE_W'(v) && sw_pl.slot == SLOT_W'(s))
                  v_q[v][s] <= sw_merged;
            end
         end
      end
   end

   ccr_upd_flag u_flag (
      .clk(clk), .rst_n(rst_n), .wr(sw_wen), .ack(upd_ack),
      .pend(upd_pend), .pulse(upd_pulse));

   AST_MASK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sw_wen) && !$past(hw_wen) && $past(sw_pl.bank) != BK_NONE &&
       $stable(sw_reg) && $stable(sw_sel) && $stable(sw_tid))
      |-> (((sw_rdata & wmask_of({sw_reg, sw_sel})) == ($past(sw_wdata) & wmask_of({sw_reg, sw_sel}))) &&
           ((sw_rdata & ~wmask_of({sw_reg, sw_sel})) == ($past(sw_rdata) & ~wmask_of({sw_reg, sw_sel}))))); // R2
   AST_RAW_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hw_wen) && $past(hw_pl.bank) != BK_NONE && $past(hw_pl.bank) != BK_VPE &&
       sw_reg == $past(hw_reg) && sw_sel == $past(hw_sel) && sw_tid == $past(hw_tid))
      |-> (sw_rdata == $past(hw_wdata))); // R9
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pl.bank == BK_NONE) |-> (sw_rdata == '0)); // R10
endmodule

// File: tb/ccr_regfile_tb.sv
module ccr_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  sw_tid = '0, hw_tid = '0;
   logic [4:0]  sw_reg = '0, hw_reg = '0;
   logic [2:0]  sw_sel = '0, hw_sel = '0;
   logic        sw_wen = 1'b0, hw_wen = 1'b0, upd_ack = 1'b0;
   logic [31:0] sw_wdata = '0, hw_wdata = '0;
   logic [31:0] sw_rdata;
   logic        upd_pend, upd_pulse;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   ccr_regfile #(.NUM_TC(4), .NUM_VPE(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sw_tid(sw_tid), .sw_reg(sw_reg), .sw_sel(sw_sel), .sw_wen(sw_wen),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .hw_wen(hw_wen), .hw_tid(hw_tid), .hw_reg(hw_reg), .hw_sel(hw_sel),
      .hw_wdata(hw_wdata), .upd_ack(upd_ack),
      .upd_pend(upd_pend), .upd_pulse(upd_pulse));

   always @(negedge clk) if (rst_n && upd_pulse) pulses++;

   // {we, hw, idx, tid, wdata, expected read}
   localparam int NV = 31;
   localparam logic [75:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'd96,  2'd0, 32'hFFFF_FFFF, 32'hFF78_FF17}, // R2 R3
      {1'b0, 1'b0, 8'd96,  2'd1, 32'h0,         32'h0040_0004}, // R6
      {1'b1, 1'b0, 8'd104, 2'd0, 32'hFFFF_FFFF, 32'h08C0_0300}, // R3
      {1'b1, 1'b0, 8'd104, 2'd0, 32'h0,         32'h0},         // R2
      {1'b1, 1'b0, 8'd128, 2'd0, 32'h0,         32'h8000_0000}, // R2
      {1'b1, 1'b0, 8'd128, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_0007}, // R3
      {1'b1, 1'b0, 8'd120, 2'd0, 32'hFFFF_FFFF, 32'h0},         // R4
      {1'b1, 1'b0, 8'd8,   2'd0, 32'h0,         32'h0000_003F}, // R4
      {1'b1, 1'b0, 8'd121, 2'd0, 32'hFFFF_FFFF, 32'hBFFF_F000}, // R1 R3
      {1'b1, 1'b0, 8'd18,  2'd2, 32'h0000_0001, 32'h0000_0001}, // R6
      {1'b0, 1'b0, 8'd121, 2'd2, 32'h0,         32'h8000_0000}, // R7
      {1'b1, 1'b0, 8'd121, 2'd2, 32'h0,         32'h8000_0000}, // R7
      {1'b0, 1'b0, 8'd121, 2'd0, 32'h0,         32'hBFFF_F000}, // R7
      {1'b1, 1'b0, 8'd4,   2'd0, 32'hFFFF_FFFF, 32'h0},         // R10
      {1'b0, 1'b0, 8'd18,  2'd3, 32'h0,         32'h0060_0000}, // R5
      {1'b1, 1'b0, 8'd0,   2'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF}, // R3
      {1'b1, 1'b0, 8'd40,  2'd0, 32'hFFFF_FFFF, 32'h1FFF_F800}, // R3
      {1'b1, 1'b0, 8'd136, 2'd1, 32'hFFFF_FFFF, 32'h0},         // R4
      {1'b1, 1'b0, 8'd98,  2'd0, 32'hFFFF_FFFF, 32'h0000_F3C0}, // R3
      {1'b1, 1'b0, 8'd97,  2'd0, 32'hFFFF_FFFF, 32'h0000_03E0}, // R3
      {1'b1, 1'b0, 8'd32,  2'd0, 32'hFFFF_FFFF, 32'hFF80_0000}, // R3
      {1'b1, 1'b0, 8'd130, 2'd0, 32'hFFFF_FFFF, 32'h7000_F000}, // R3
      {1'b1, 1'b0, 8'd41,  2'd0, 32'hFFFF_FFFF, 32'h1000_0000}, // R3
      {1'b1, 1'b0, 8'd24,  2'd0, 32'hFFFF_FFFF, 32'h3FFF_FFFF}, // R3
      {1'b1, 1'b1, 8'd120, 2'd0, 32'h1234_5678, 32'h1234_5678}, // R8
      {1'b1, 1'b0, 8'd120, 2'd0, 32'h0,         32'h1234_5678}, // R4
      {1'b1, 1'b1, 8'd121, 2'd2, 32'h0000_0ABC, 32'h0000_0ABC}, // R8 R7
      {1'b0, 1'b0, 8'd121, 2'd3, 32'h0,         32'hBFFF_F000}, // R7
      {1'b1, 1'b0, 8'd96,  2'd2, 32'h0,         32'h0},         // R6
      {1'b0, 1'b0, 8'd96,  2'd3, 32'h0,         32'h0040_0004}, // R6
      {1'b1, 1'b0, 8'd255, 2'd0, 32'hFFFF_FFFF, 32'h0}          // R10
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] idx, input logic [1:0] tid, input string tag,
                     input logic [31:0] exp);
      @(negedge clk);
      {sw_reg, sw_sel} = idx;
      sw_tid = tid;
      #1;
      chk(tag, sw_rdata, exp);
   endtask

   task automatic run_vec(input logic [75:0] v, input int n);
      logic [7:0] idx;
      logic [1:0] tid;
      idx = v[73:66];
      tid = v[65:64];
      @(negedge clk);
      {sw_reg, sw_sel} = idx;
      sw_tid = tid;
      if (v[75]) begin
         if (v[74]) begin
            {hw_reg, hw_sel} = idx; hw_tid = tid; hw_wdata = v[63:32]; hw_wen = 1'b1;
         end else begin
            sw_wdata = v[63:32]; sw_wen = 1'b1;
         end
         @(negedge clk);
         sw_wen = 1'b0;
         hw_wen = 1'b0;
      end
      #1;
      chk($sformatf("vector %0d", n), sw_rdata, v[31:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(8'd8,   2'd0, "R5 random reset",   32'h0000_003F);
      rd(8'd96,  2'd3, "R5 status reset",   32'h0040_0004);
      rd(8'd121, 2'd0, "R5 ebase reset",    32'h8000_0000);
      rd(8'd128, 2'd0, "R5 config reset",   32'h8000_0000);
      rd(8'd18,  2'd3, "R5 bind reset",     32'h0060_0000);
      rd(8'd120, 2'd0, "R5 prid reset",     32'h0);
      chk("R11 pend after reset", {31'b0, upd_pend}, 32'h0);
      pulses = 0;
      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
      @(negedge clk);
      chk("R11 single pulse for many writes", pulses, 1);
      chk("R11 pend held", {31'b0, upd_pend}, 32'h1);
      upd_ack = 1'b1;
      @(negedge clk);
      upd_ack = 1'b0;
      chk("R11 ack clears", {31'b0, upd_pend}, 32'h0);
      sw_reg = 5'd13; sw_sel = 3'd0; sw_tid = 2'd0; sw_wdata = 32'h0000_0100; sw_wen = 1'b1;
      @(negedge clk);
      sw_wen = 1'b0;
      chk("R11 new pulse after ack", {31'b0, upd_pulse}, 32'h1);
      @(negedge clk);
      chk("R11 pulse count", pulses, 2);
      // R9: both ports hit the cause register of thread 0 in one cycle
      sw_wdata = 32'hFFFF_FFFF; sw_wen = 1'b1;
      hw_reg = 5'd13; hw_sel = 3'd0; hw_tid = 2'd0; hw_wdata = 32'h1111_1111; hw_wen = 1'b1;
      @(negedge clk);
      sw_wen = 1'b0; hw_wen = 1'b0;
      #1;
      chk("R9 raw wins collision", sw_rdata, 32'h1111_1111);
      rd(8'd9,  2'd2, "R7 vpe1 control", 32'h0);
      rd(8'd17, 2'd1, "R6 tc status",    32'h0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule